// File: doc/BRIEF.md
# SPI Register-Access Slave Port

This block lets an external controller read and write a byte-wide register map over a serial control link. Every transfer opens with a 16-bit instruction word. The word gives the direction, the payload length and the starting register address. Data bytes follow the instruction, and the register address moves by one after each byte. The payload length is either a fixed count of one to three bytes or an open stream that ends when chip select is released.

SCLK, chip select and the serial input are sampled by a fast system clock. Each SCLK and chip-select phase must last at least four system clock cycles. The register map sees a 13-bit address, a one-cycle write strobe with its data, and a read-data byte that it returns combinationally.

A small configuration byte at address 0 lives inside the port and is never passed to the map. It selects the bit order (MSB-first or LSB-first) and the wiring. In 3-wire wiring, read data is driven on the shared data line. In 4-wire wiring, read data goes out on a dedicated output.

Top module: `spi_ctrl_port`

## Requirements
- R1: After reset the port uses MSB-first order and 3-wire wiring, both output enables are low, and a read of address 0 returns 0x00.
- R2: The first 16 SCLK rising edges after chip select falls carry the instruction: bit 15 is the direction (1 = read), bits 14:13 are the count field and bits 12:0 are the start address. The bits arrive in the current bit order, so the first bit received is bit 15 in MSB-first mode and bit 0 in LSB-first mode.
- R3: Count field 00 moves one byte, 01 moves two and 10 moves three. SCLK edges after the last byte of a fixed-count transfer cause no write.
- R4: Count field 11 streams any number of bytes. Raising chip select on a byte boundary ends the stream, and the next transfer starts from a fresh instruction.
- R5: After each data byte the address decrements by one in MSB-first mode and increments by one in LSB-first mode.
- R6: `reg_wr` pulses for exactly one system clock cycle after the 8th bit of each written byte. `reg_addr` holds that byte's address during the pulse and steps on the next cycle.
- R7: Read bits are driven on falling SCLK edges in the current bit order. In 3-wire mode they appear on `sdio_o` with `sdio_oe` high. In 4-wire mode they appear on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low.
- R8: In a fixed-count transfer, chip select may rise on any byte boundary of the instruction or the payload. The port holds its position and continues when chip select falls again.
- R9: If chip select rises in the middle of a byte, the partial byte is discarded, no write is issued and the port returns to idle.
- R10: Address 0 is the internal configuration byte. Bit 0 = 1 selects LSB-first order and bit 1 = 1 selects 4-wire wiring. A write to address 0 produces no `reg_wr`, and the byte reads back through the port.
- R11: While `csn_i` is high, `sdio_oe` and `sdo_oe` are both low.
- R12: No write strobe is issued while read data is being driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| csn_i | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data input (shared line in 3-wire mode) |
| sdio_o | output | 1 | Read data for the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo_o | output | 1 | Read data for the dedicated output in 4-wire mode |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| reg_addr | output | 13 | Register map address of the current byte |
| reg_wr | output | 1 | One-cycle write strobe to the register map |
| reg_wdata | output | 8 | Write data, valid while `reg_wr` is high |
| reg_rdata | input | 8 | Read data returned by the register map for `reg_addr` |

## Verification
The assertions check on every cycle that each write strobe lasts a single cycle, that the address then steps in the direction the bit order selects, and that no write coincides with an active read driver. Instruction decoding, the fixed and streaming byte counts, stall and resume at byte boundaries, mid-byte abort, the internal configuration byte and the bit order of read data involve whole serial sequences. Only the bench's scenarios show these, by comparing register-map contents, strobe counts and shifted-out bytes with expected values.

// File: rtl/spi_port_pkg.sv
// Shared widths, state encoding and configuration field positions for the
// serial register-access port. Assumes byte-wide registers and a 16-bit
// instruction made of direction, two-bit count and address.
package spi_port_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 13;
    localparam int INSTR_W = 2 * DATA_W;
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int CFG_W   = 2;
    localparam int CFG_LSB_BIT = 0;
    localparam int CFG_4W_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2,
        ST_DONE = 2'd3
    } xfer_st_t;

    // Address after one byte: up in LSB-first order, down in MSB-first order.
    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                    input logic lsb);
        return lsb ? a + ADDR_W'(1) : a - ADDR_W'(1);
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchronizer for asynchronous serial pins.
// Assumes each lane is a slow level compared with clk; RST_VAL gives the
// idle level of each lane so that no false edge follows reset.
module spi_pin_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_s
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        // Shift the raw pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], pin_i[g]};
        end
        assign pin_s[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_port_cfg.sv
// Configuration byte held inside the port (bit order and wiring select).
// Assumes the caller asserts wr_en only for writes aimed at address 0.
module spi_port_cfg import spi_port_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wbits,
    output logic             lsb_first,
    output logic             four_wire
);
    logic [CFG_W-1:0] cfg_q;
    // Hold the configuration; reset gives MSB-first, 3-wire.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wbits;
    end
    assign lsb_first = cfg_q[CFG_LSB_BIT];
    assign four_wire = cfg_q[CFG_4W_BIT];
endmodule

// File: rtl/spi_xfer_fsm.sv
// Transfer engine: detects SCLK and chip-select edges on synchronized
// levels, assembles the instruction, counts payload bytes, steps the
// address, issues write strobes and shifts read data on falling edges.
// Assumes each SCLK phase spans at least four clk cycles, so the read
// byte is loaded before its first falling edge.
module spi_xfer_fsm import spi_port_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              din_s,
    input  logic              lsb_first,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] byte_addr,
    output logic              byte_wr,
    output logic [DATA_W-1:0] byte_data,
    output logic              out_bit,
    output logic              drive
);
    xfer_st_t          st_q;
    logic              sclk_q, csn_q;
    logic [CNT_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q, first_q, tx_q, wdata_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        left_q;
    logic              second_q, data_q, rw_q, stream_q;
    logic              step_q, load_q, wr_q, obit_q;

    logic              sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic [DATA_W-1:0] nb;
    logic [INSTR_W-1:0] instr_w;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_rise   = csn_s & ~csn_q;
    assign cs_fall   = ~csn_s & csn_q;
    assign nb        = lsb_first ? {din_s, sh_q[DATA_W-1:1]} : {sh_q[DATA_W-2:0], din_s};
    assign instr_w   = lsb_first ? {nb, first_q} : {first_q, nb};

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    // Main transfer sequencing, address stepping and data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; first_q <= '0;
            tx_q <= '0; wdata_q <= '0; addr_q <= '0; left_q <= '0;
            second_q <= 1'b0; data_q <= 1'b0; rw_q <= 1'b0; stream_q <= 1'b0;
            step_q <= 1'b0; load_q <= 1'b0; wr_q <= 1'b0; obit_q <= 1'b0;
        end else begin
            wr_q   <= 1'b0;
            step_q <= 1'b0;
            load_q <= step_q;
            if (step_q) addr_q <= next_addr(addr_q, lsb_first);
            if (load_q) tx_q <= rd_byte;
            unique case (st_q)
                ST_IDLE: if (cs_fall) begin
                    st_q <= ST_RUN; bit_q <= '0; second_q <= 1'b0; data_q <= 1'b0;
                end
                ST_RUN: begin
                    if (cs_rise) begin
                        if (bit_q != '0)             st_q <= ST_IDLE;
                        else if (data_q)             st_q <= stream_q ? ST_IDLE : ST_HOLD;
                        else if (!second_q)          st_q <= ST_IDLE;
                        else                         st_q <= ST_HOLD;
                    end else if (sclk_rise) begin
                        sh_q  <= nb;
                        bit_q <= bit_q + CNT_W'(1);
                        if (bit_q == CNT_W'(DATA_W - 1)) begin
                            if (!data_q && !second_q) begin
                                first_q  <= nb;
                                second_q <= 1'b1;
                            end else if (!data_q) begin
                                data_q   <= 1'b1;
                                rw_q     <= instr_w[INSTR_W-1];
                                stream_q <= &instr_w[INSTR_W-2 -: 2];
                                left_q   <= instr_w[INSTR_W-2 -: 2] + 2'd1;
                                addr_q   <= instr_w[ADDR_W-1:0];
                                load_q   <= 1'b1;
                            end else begin
                                wr_q    <= ~rw_q;
                                wdata_q <= nb;
                                step_q  <= 1'b1;
                                if (!stream_q) begin
                                    left_q <= left_q - 2'd1;
                                    if (left_q == 2'd1) st_q <= ST_DONE;
                                end
                            end
                        end
                    end
                    if (sclk_fall && data_q && rw_q) begin
                        obit_q <= lsb_first ? tx_q[0] : tx_q[DATA_W-1];
                        tx_q   <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
                    end
                end
                ST_HOLD: if (cs_fall) st_q <= ST_RUN;
                ST_DONE: if (cs_rise) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign byte_addr = addr_q;
    assign byte_wr   = wr_q;
    assign byte_data = wdata_q;
    assign out_bit   = obit_q;
    assign drive     = rw_q & data_q & (st_q != ST_IDLE);
endmodule

// File: rtl/spi_ctrl_port.sv
// Top of the serial register-access slave port. Synchronizes the pins,
// runs the transfer engine, decodes the internal configuration byte at
// address 0 and forms the output drive enables.
// Assumes reg_rdata is a combinational function of reg_addr.
module spi_ctrl_port import spi_port_pkg::*; #(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [2:0]        pins_s;
    logic              lsb_first, four_wire, cfg_hit, byte_wr, out_bit, drive;
    logic [ADDR_W-1:0] byte_addr;
    logic [DATA_W-1:0] byte_data, rd_byte;

    spi_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_i({sdio_i, csn_i, sclk_i}), .pin_s(pins_s)
    );

    spi_port_cfg u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(byte_wr & cfg_hit), .wbits(byte_data[CFG_W-1:0]),
        .lsb_first(lsb_first), .four_wire(four_wire)
    );

    spi_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[0]), .csn_s(pins_s[1]), .din_s(pins_s[2]),
        .lsb_first(lsb_first), .rd_byte(rd_byte),
        .byte_addr(byte_addr), .byte_wr(byte_wr), .byte_data(byte_data),
        .out_bit(out_bit), .drive(drive)
    );

    assign cfg_hit   = (byte_addr == '0);
    assign rd_byte   = cfg_hit ? {{(DATA_W-CFG_W){1'b0}}, four_wire, lsb_first} : reg_rdata;
    assign reg_addr  = byte_addr;
    assign reg_wr    = byte_wr & ~cfg_hit;
    assign reg_wdata = byte_data;
    assign sdio_o    = out_bit;
    assign sdo_o     = out_bit;
    assign sdio_oe   = drive & ~csn_i & ~four_wire;
    assign sdo_oe    = drive & ~csn_i & four_wire;
endmodule

// File: rtl/spi_ctrl_port_chk.sv
// Property checker for the serial register-access port, bound to its top.
// Assumes it sees the top's ports plus the active bit-order setting.
module spi_ctrl_port_chk import spi_port_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              sdio_oe,
    input logic              sdo_oe,
    input logic              lsb_first
);
    assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !lsb_first) |=> (reg_addr == $past(reg_addr) - ADDR_W'(1)));

    assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && lsb_first) |=> (reg_addr == $past(reg_addr) + ADDR_W'(1)));

    assert_no_wr_in_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe || sdo_oe) |-> !reg_wr);
endmodule

bind spi_ctrl_port spi_ctrl_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .sdio_oe(sdio_oe), .sdo_oe(sdo_oe), .lsb_first(lsb_first)
);

// File: tb/sim_spi_ctrl_port.sv
module sim_spi_ctrl_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe, reg_wr;
    logic [12:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [7:0]  mem [16];
    int wr_cnt = 0;
    int checks = 0, errors = 0;
    bit b_lsb = 0, b_4w = 0, saw_sdio_oe = 0, saw_sdo_oe = 0, done = 0;

    spi_ctrl_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdio_i(mosi),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register map model: 16 bytes, initial contents 0x40 + index.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'(8'h40 + i);
        end else if (reg_wr) begin
            mem[reg_addr[3:0]] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end
    assign reg_rdata = mem[reg_addr[3:0]];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            int idx = b_lsb ? i : 7 - i;
            @(negedge clk) mosi = tx[idx];
            repeat (HALF - 1) @(negedge clk);
            rx[idx] = b_4w ? sdo_o : sdio_o;
            if (sdio_oe) saw_sdio_oe = 1;
            if (sdo_oe)  saw_sdo_oe  = 1;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        shift_bits(tx, 8, rx);
    endtask

    function automatic logic [15:0] mk_instr(input logic rd, input logic [1:0] w,
                                             input logic [12:0] a);
        return {rd, w, a};
    endfunction

    task automatic instr_byte(input logic [15:0] ins, input int k);
        logic [7:0] d;
        logic [7:0] b = ((k == 0) ^ b_lsb) ? ins[15:8] : ins[7:0];
        xbyte(b, d);
    endtask

    task automatic send_instr(input logic rd, input logic [1:0] w, input logic [12:0] a);
        instr_byte(mk_instr(rd, w, a), 0);
        instr_byte(mk_instr(rd, w, a), 1);
    endtask

    task automatic cs_on;
        @(negedge clk) csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_off;
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] rx;
        check("R1 sdio_oe after reset", sdio_oe, 0);
        check("R1 sdo_oe after reset", sdo_oe, 0);
        check("R11 reg_wr idle", reg_wr, 0);
        saw_sdio_oe = 0; saw_sdo_oe = 0;
        cs_on; send_instr(1, 2'b00, 13'h0); xbyte(8'h00, rx); cs_off;
        check("R1 R10 config reads zero", rx, 8'h00);
        check("R7 3-wire drives sdio", saw_sdio_oe, 1);
        check("R7 3-wire leaves sdo off", saw_sdo_oe, 0);
    endtask

    task automatic t_write_single;
        logic [7:0] rx;
        int base = wr_cnt;
        cs_on; send_instr(0, 2'b00, 13'd5); xbyte(8'hA5, rx); cs_off;
        check("R2 R6 single write data", mem[5], 8'hA5);
        check("R6 one strobe", wr_cnt - base, 1);
    endtask

    task automatic t_write_three;
        logic [7:0] rx;
        cs_on; send_instr(0, 2'b10, 13'd9);
        xbyte(8'h31, rx); xbyte(8'h32, rx); xbyte(8'h33, rx); cs_off;
        check("R3 R5 three byte first", mem[9], 8'h31);
        check("R3 R5 three byte second", mem[8], 8'h32);
        check("R3 R5 three byte third", mem[7], 8'h33);
    endtask

    task automatic t_read_two;
        logic [7:0] r0, r1;
        int base = wr_cnt;
        cs_on; send_instr(1, 2'b01, 13'd3); xbyte(8'h00, r0); xbyte(8'h00, r1); cs_off;
        check("R7 read first byte", r0, 8'h43);
        check("R5 R7 read second byte", r1, 8'h42);
        check("R12 no write in read", wr_cnt - base, 0);
        check("R11 sdio_oe off after cs high", sdio_oe, 0);
    endtask

    task automatic t_stall;
        logic [7:0] rx;
        cs_on; instr_byte(mk_instr(0, 2'b01, 13'd13), 0); cs_off;
        cs_on; instr_byte(mk_instr(0, 2'b01, 13'd13), 1); cs_off;
        cs_on; xbyte(8'h5A, rx); cs_off;
        check("R8 stalled first byte", mem[13], 8'h5A);
        cs_on; xbyte(8'h5B, rx); cs_off;
        check("R8 stalled second byte", mem[12], 8'h5B);
    endtask

    task automatic t_abort;
        logic [7:0] rx;
        int base = wr_cnt;
        cs_on; send_instr(0, 2'b00, 13'd4); shift_bits(8'hF0, 4, rx); cs_off;
        check("R9 no write on abort", wr_cnt - base, 0);
        check("R9 target untouched", mem[4], 8'h44);
        cs_on; send_instr(0, 2'b00, 13'd4); xbyte(8'h3C, rx); cs_off;
        check("R9 idle after abort", mem[4], 8'h3C);
    endtask

    task automatic t_fixed_extra;
        logic [7:0] rx;
        int base = wr_cnt;
        cs_on; send_instr(0, 2'b00, 13'd10); xbyte(8'h11, rx); xbyte(8'h22, rx); cs_off;
        check("R3 only counted byte written", wr_cnt - base, 1);
        check("R3 counted byte data", mem[10], 8'h11);
        check("R3 next address untouched", mem[9], 8'h31);
    endtask

    task automatic t_stream;
        logic [7:0] rx;
        int base = wr_cnt;
        cs_on; send_instr(0, 2'b11, 13'd15);
        for (int i = 0; i < 5; i++) xbyte(8'(8'hC0 + i), rx);
        cs_off;
        check("R4 stream strobes", wr_cnt - base, 5);
        for (int i = 0; i < 5; i++)
            check("R4 R5 stream data", mem[15 - i], 8'(8'hC0 + i));
        cs_on; send_instr(0, 2'b00, 13'd1); xbyte(8'h77, rx); cs_off;
        check("R4 new instruction after stream", mem[1], 8'h77);
    endtask

    task automatic t_config;
        logic [7:0] rx;
        int base = wr_cnt;
        cs_on; send_instr(0, 2'b00, 13'd0); xbyte(8'h03, rx); cs_off;
        check("R10 config write stays internal", wr_cnt - base, 0);
        b_lsb = 1; b_4w = 1; saw_sdio_oe = 0; saw_sdo_oe = 0;
        cs_on; send_instr(1, 2'b00, 13'd0); xbyte(8'h00, rx); cs_off;
        check("R10 config readback", rx, 8'h03);
        check("R7 4-wire drives sdo", saw_sdo_oe, 1);
        check("R7 4-wire keeps sdio off", saw_sdio_oe, 0);
    endtask

    task automatic t_lsb;
        logic [7:0] r0, r1;
        cs_on; send_instr(0, 2'b01, 13'd6); xbyte(8'h66, r0); xbyte(8'h67, r0); cs_off;
        check("R2 R5 lsb write first", mem[6], 8'h66);
        check("R5 lsb write increments", mem[7], 8'h67);
        cs_on; send_instr(1, 2'b01, 13'd6); xbyte(8'h00, r0); xbyte(8'h00, r1); cs_off;
        check("R7 lsb read first", r0, 8'h66);
        check("R7 lsb read second", r1, 8'h67);
        check("R11 sdo_oe off after cs high", sdo_oe, 0);
        check("R11 sdio_oe off after cs high", sdio_oe, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_write_single;
        t_write_three;
        t_read_two;
        t_stall;
        t_abort;
        t_fixed_extra;
        t_stream;
        t_config;
        t_lsb;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule